// File: doc/BRIEF.md
# Shared Semaphore Register Cluster

This block holds a bank of shared register clusters that several processors use to hand data to each other and to coordinate. Each cluster has eight 24-bit shared address registers, eight 64-bit shared scalar registers and 32 one-bit semaphores. A processor first programs its own cluster-select register. From then on, each request it makes on its read/write port reaches only the cluster it selected.

Semaphores offer three operations: clear, set, and test-and-set. Test-and-set waits while the bit is already set, and takes the bit as soon as the bit is found clear. When several processors contend in the same cycle, a rotating priority picks one winner, so a semaphore bit is never acquired twice and a register never takes two writes at once. Reads, clears and sets never wait. The response to a request appears in the same cycle, and any state change becomes visible at the next clock edge.

Top module: `shared_sync_cluster`

## Requirements
- R1: After reset every cluster-select register is 0, all shared registers and semaphores are 0, and the priority pointer is 0.
- R2: Writing value v to a processor's cluster-select register takes effect from the next cycle. A value v from 1 to NUM_CLUSTERS selects cluster v-1. A value of 0 or a value above NUM_CLUSTERS makes every request return rsp_err=1, rsp_ready=1 and rdata 0, with no change to any state.
- R3: Op 0 reads and op 1 writes the 24-bit address register idx[2:0]. A write keeps wdata[23:0], and a read returns the value zero-extended to 64 bits. A write is seen by every processor on the same cluster from the next cycle, and other clusters are unaffected.
- R4: Op 2 reads and op 3 writes the 64-bit scalar register idx[2:0], with the same visibility rules as R3.
- R5: Op 4 is test-and-set of semaphore idx. If the bit is clear and the request wins arbitration, rsp_ready is 1 in that cycle and the bit reads as set from the next cycle. If the bit is set, rsp_ready stays 0, nothing changes, and the request is retried every cycle it is held.
- R6: Op 5 clears and op 6 sets semaphore idx. Both always complete in one cycle with rsp_ready=1. If the same bit is set and cleared in one cycle, the set wins.
- R7: Op 7 returns all 32 semaphores of the cluster in rdata[31:0], with bit k holding semaphore k and the upper bits 0.
- R8: When several processors test-and-set the same clear bit of one cluster in one cycle, exactly one is granted and the others keep waiting.
- R9: The priority pointer names the highest-priority processor, and priority then falls by increasing index with wrap-around. The pointer advances by one after any cycle in which some request lost arbitration, and holds otherwise.
- R10: Simultaneous writes to the same register of the same cluster are serialised by the priority of R9, and the losers wait with rsp_ready=0. Writes to different registers or clusters all complete in the same cycle.
- R11: Reads never wait. A read returns the value stored at the start of the cycle, so a write in the same cycle shows up only from the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_we | input | NUM_CPU | Per-processor cluster-select write strobe |
| sel_val | input | NUM_CPU*SELW | Per-processor cluster-select value |
| req_valid | input | NUM_CPU | Request present |
| req_op | input | NUM_CPU*3 | Operation code (R3 to R7) |
| req_idx | input | NUM_CPU*IDXW | Register or semaphore index |
| req_wdata | input | NUM_CPU*SCAL_W | Write data |
| rsp_ready | output | NUM_CPU | Request completes this cycle |
| rsp_err | output | NUM_CPU | Request refused: no valid cluster selected |
| rsp_rdata | output | NUM_CPU*SCAL_W | Read data |

## Verification
Single-processor vectors first show that each operation behaves correctly when nothing competes with it: reads and writes across clusters, refused selects, and a test-and-set that is then released. Paired requests then tell apart real contention (same key, so one winner) from mere coincidence (different registers or clusters, so all complete). The same conflict is repeated at several pointer values to separate a rotating order from a fixed one. A set and a clear on one bit, and a write and a read on one register in one cycle, then expose the ordering rules.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [2:0] {
    OP_RD_ADDR = 3'd0,
    OP_WR_ADDR = 3'd1,
    OP_RD_SCAL = 3'd2,
    OP_WR_SCAL = 3'd3,
    OP_SEM_TAS = 3'd4,
    OP_SEM_CLR = 3'd5,
    OP_SEM_SET = 3'd6,
    OP_SEM_ALL = 3'd7
  } op_e;

  // contention kinds used in the arbitration key
  localparam logic [1:0] KIND_ADDR = 2'd1;
  localparam logic [1:0] KIND_SCAL = 2'd2;
  localparam logic [1:0] KIND_SEM  = 2'd3;

  // rank 0 is the highest priority
  function automatic int unsigned prio_rank(int unsigned cpu, int unsigned ptr,
                                            int unsigned n);
    return (cpu + n - ptr) % n;
  endfunction

  // a select value names a cluster when it lies in 1..nclu
  function automatic bit sel_ok(int unsigned sel, int unsigned nclu);
    return (sel != 0) && (sel <= nclu);
  endfunction

  function automatic bit is_reg_write(op_e op);
    return (op == OP_WR_ADDR) || (op == OP_WR_SCAL);
  endfunction

  function automatic bit never_waits(op_e op);
    return (op == OP_RD_ADDR) || (op == OP_RD_SCAL) || (op == OP_SEM_CLR) ||
           (op == OP_SEM_SET) || (op == OP_SEM_ALL);
  endfunction

endpackage

// File: rtl/ssc_sel_bank.sv
module ssc_sel_bank #(
  parameter int N    = 4,
  parameter int SELW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    we,
  input  logic [N*SELW-1:0] wval,
  output logic [N*SELW-1:0] sel_q
);

  for (genvar g = 0; g < N; g++) begin : g_sel
    logic [SELW-1:0] r_q;
    always_ff @(posedge clk) begin
      if (!rst_n)     r_q <= '0;
      else if (we[g]) r_q <= wval[g*SELW +: SELW];
    end
    assign sel_q[g*SELW +: SELW] = r_q;
  end

endmodule

// File: rtl/ssc_arbiter.sv
module ssc_arbiter
  import ssc_pkg::*;
#(
  parameter int N    = 4,
  parameter int KEYW = 11,
  localparam int PW  = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    contend,
  input  logic [N*KEYW-1:0] key,
  output logic [N-1:0]    win,
  output logic [N-1:0]    lost,
  output logic [PW-1:0]   ptr_q
);

  logic [KEYW-1:0] key_v [N];

  for (genvar g = 0; g < N; g++) begin : g_key
    assign key_v[g] = key[g*KEYW +: KEYW];
  end

  always_comb begin
    lost = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (j != i && contend[i] && contend[j] && key_v[i] == key_v[j] &&
            prio_rank(j, int'(ptr_q), N) < prio_rank(i, int'(ptr_q), N))
          lost[i] = 1'b1;
      end
    end
  end

  assign win = contend & ~lost;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (|lost)
      ptr_q <= (int'(ptr_q) == N - 1) ? '0 : ptr_q + PW'(1);
  end

endmodule

// File: rtl/ssc_store.sv
module ssc_store #(
  parameter int N    = 4,
  parameter int NC   = 16,
  parameter int NR   = 8,
  parameter int NS   = 32,
  parameter int AW   = 24,
  parameter int SW   = 64,
  localparam int CLW  = $clog2(NC),
  localparam int IDXW = $clog2(NS),
  localparam int RIW  = $clog2(NR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      wr_a_en,
  input  logic [N-1:0]      wr_s_en,
  input  logic [N-1:0]      set_en,
  input  logic [N-1:0]      clr_en,
  input  logic [N*CLW-1:0]  cl,
  input  logic [N*IDXW-1:0] idx,
  input  logic [N*SW-1:0]   wdata,
  output logic [N*AW-1:0]   rd_a,
  output logic [N*SW-1:0]   rd_s,
  output logic [N*NS-1:0]   rd_sem,
  output logic [N-1:0]      tgt_bit,
  output logic [NC*NS-1:0]  sem_all
);

  logic [AW-1:0] areg [NC*NR];
  logic [SW-1:0] sreg [NC*NR];
  logic [NS-1:0] sem_q [NC];
  logic [NS-1:0] set_m [NC];
  logic [NS-1:0] clr_m [NC];

  logic [CLW-1:0]  cl_v  [N];
  logic [IDXW-1:0] idx_v [N];

  function automatic int reg_slot(logic [CLW-1:0] c, logic [RIW-1:0] r);
    return int'(c) * NR + int'(r);
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_port
    assign cl_v[g]  = cl[g*CLW +: CLW];
    assign idx_v[g] = idx[g*IDXW +: IDXW];
    assign rd_a[g*AW +: AW]   = areg[reg_slot(cl_v[g], idx_v[g][RIW-1:0])];
    assign rd_s[g*SW +: SW]   = sreg[reg_slot(cl_v[g], idx_v[g][RIW-1:0])];
    assign rd_sem[g*NS +: NS] = sem_q[cl_v[g]];
    assign tgt_bit[g]         = sem_q[cl_v[g]][idx_v[g]];
  end

  for (genvar c = 0; c < NC; c++) begin : g_flat
    assign sem_all[c*NS +: NS] = sem_q[c];
  end

  // gather every semaphore update of the cycle into per-cluster masks
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      set_m[c] = '0;
      clr_m[c] = '0;
    end
    for (int i = 0; i < N; i++) begin
      if (set_en[i]) set_m[cl_v[i]][idx_v[i]] = 1'b1;
      if (clr_en[i]) clr_m[cl_v[i]][idx_v[i]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NC * NR; k++) begin
        areg[k] <= '0;
        sreg[k] <= '0;
      end
      for (int c = 0; c < NC; c++) sem_q[c] <= '0;
    end else begin
      for (int c = 0; c < NC; c++)
        sem_q[c] <= (sem_q[c] & ~clr_m[c]) | set_m[c];
      for (int i = 0; i < N; i++) begin
        if (wr_a_en[i])
          areg[reg_slot(cl_v[i], idx_v[i][RIW-1:0])] <= wdata[i*SW +: AW];
        if (wr_s_en[i])
          sreg[reg_slot(cl_v[i], idx_v[i][RIW-1:0])] <= wdata[i*SW +: SW];
      end
    end
  end

endmodule

// File: rtl/shared_sync_cluster.sv
module shared_sync_cluster
  import ssc_pkg::*;
#(
  parameter int NUM_CPU      = 4,
  parameter int NUM_CLUSTERS = 16,
  parameter int NUM_REGS     = 8,
  parameter int NUM_SEMS     = 32,
  parameter int ADDR_W       = 24,
  parameter int SCAL_W       = 64,
  localparam int SELW = $clog2(NUM_CLUSTERS + 1),
  localparam int CLW  = $clog2(NUM_CLUSTERS),
  localparam int IDXW = $clog2(NUM_SEMS),
  localparam int RIW  = $clog2(NUM_REGS),
  localparam int KEYW = 2 + CLW + IDXW,
  localparam int PW   = $clog2(NUM_CPU)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CPU-1:0]         sel_we,
  input  logic [NUM_CPU*SELW-1:0]    sel_val,
  input  logic [NUM_CPU-1:0]         req_valid,
  input  logic [NUM_CPU*3-1:0]       req_op,
  input  logic [NUM_CPU*IDXW-1:0]    req_idx,
  input  logic [NUM_CPU*SCAL_W-1:0]  req_wdata,
  output logic [NUM_CPU-1:0]         rsp_ready,
  output logic [NUM_CPU-1:0]         rsp_err,
  output logic [NUM_CPU*SCAL_W-1:0]  rsp_rdata
);

  localparam int N = NUM_CPU;

  // named internal events, observed by the bound checker
  logic [N*SELW-1:0]     sel_q;
  logic [N-1:0]          act;
  logic [N-1:0]          contend;
  logic [N-1:0]          win;
  logic [N-1:0]          lost;
  logic [N-1:0]          tas_win;
  logic [N-1:0]          tgt_bit;
  logic [PW-1:0]         arb_ptr;
  logic [N*KEYW-1:0]     key;
  logic [N*CLW-1:0]      cl;
  logic [N*(CLW+IDXW)-1:0] sem_idx;
  logic [N-1:0]          wr_a_en, wr_s_en, set_en, clr_en;
  logic [N*ADDR_W-1:0]   rd_a;
  logic [N*SCAL_W-1:0]   rd_s;
  logic [N*NUM_SEMS-1:0] rd_sem;
  logic [NUM_CLUSTERS*NUM_SEMS-1:0] sem_all;

  ssc_sel_bank #(.N(N), .SELW(SELW)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (sel_we),
    .wval  (sel_val),
    .sel_q (sel_q)
  );

  for (genvar g = 0; g < N; g++) begin : g_cpu
    logic [SELW-1:0] sel;
    logic [IDXW-1:0] idx;
    logic [IDXW-1:0] key_idx;
    logic [1:0]      kind;
    op_e             op;

    assign sel = sel_q[g*SELW +: SELW];
    assign idx = req_idx[g*IDXW +: IDXW];
    assign op  = op_e'(req_op[g*3 +: 3]);

    assign rsp_err[g] = req_valid[g] & ~sel_ok(int'(sel), NUM_CLUSTERS);
    assign act[g]     = req_valid[g] & ~rsp_err[g];
    assign cl[g*CLW +: CLW] = CLW'(sel - SELW'(1));
    assign sem_idx[g*(CLW+IDXW) +: (CLW+IDXW)] = {cl[g*CLW +: CLW], idx};

    // register ops contend on the register slot, semaphores on the bit
    assign kind    = (op == OP_WR_ADDR) ? KIND_ADDR :
                     (op == OP_WR_SCAL) ? KIND_SCAL : KIND_SEM;
    assign key_idx = is_reg_write(op) ? IDXW'(idx[RIW-1:0]) : idx;
    assign key[g*KEYW +: KEYW] = {kind, cl[g*CLW +: CLW], key_idx};

    assign contend[g] = act[g] &
                        (is_reg_write(op) || (op == OP_SEM_TAS && !tgt_bit[g]));
    assign tas_win[g] = act[g] & (op == OP_SEM_TAS) & win[g];

    assign wr_a_en[g] = act[g] & (op == OP_WR_ADDR) & win[g];
    assign wr_s_en[g] = act[g] & (op == OP_WR_SCAL) & win[g];
    assign set_en[g]  = (act[g] & (op == OP_SEM_SET)) | tas_win[g];
    assign clr_en[g]  = act[g] & (op == OP_SEM_CLR);

    assign rsp_ready[g] = rsp_err[g] |
                          (act[g] & (never_waits(op) || win[g]));

    always_comb begin
      rsp_rdata[g*SCAL_W +: SCAL_W] = '0;
      if (act[g]) begin
        case (op)
          OP_RD_ADDR: rsp_rdata[g*SCAL_W +: SCAL_W] = SCAL_W'(rd_a[g*ADDR_W +: ADDR_W]);
          OP_RD_SCAL: rsp_rdata[g*SCAL_W +: SCAL_W] = rd_s[g*SCAL_W +: SCAL_W];
          OP_SEM_ALL: rsp_rdata[g*SCAL_W +: SCAL_W] = SCAL_W'(rd_sem[g*NUM_SEMS +: NUM_SEMS]);
          default:    rsp_rdata[g*SCAL_W +: SCAL_W] = '0;
        endcase
      end
    end
  end

  ssc_arbiter #(.N(N), .KEYW(KEYW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .contend (contend),
    .key     (key),
    .win     (win),
    .lost    (lost),
    .ptr_q   (arb_ptr)
  );

  ssc_store #(
    .N(N), .NC(NUM_CLUSTERS), .NR(NUM_REGS), .NS(NUM_SEMS),
    .AW(ADDR_W), .SW(SCAL_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_a_en (wr_a_en),
    .wr_s_en (wr_s_en),
    .set_en  (set_en),
    .clr_en  (clr_en),
    .cl      (cl),
    .idx     (req_idx),
    .wdata   (req_wdata),
    .rd_a    (rd_a),
    .rd_s    (rd_s),
    .rd_sem  (rd_sem),
    .tgt_bit (tgt_bit),
    .sem_all (sem_all)
  );

endmodule

// File: rtl/ssc_checker.sv
module ssc_checker
  import ssc_pkg::*;
#(
  parameter int N    = 4,
  parameter int NC   = 16,
  parameter int NS   = 32,
  parameter int SW   = 64,
  parameter int SIW  = 9,
  localparam int PW  = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N*3-1:0]   req_op,
  input logic [N-1:0]     rsp_ready,
  input logic [N-1:0]     rsp_err,
  input logic [N*SW-1:0]  rsp_rdata,
  input logic [N-1:0]     act,
  input logic [N-1:0]     tas_win,
  input logic [N-1:0]     lost,
  input logic [N-1:0]     tgt_bit,
  input logic [N*SIW-1:0] sem_idx,
  input logic [NC*NS-1:0] sem_all,
  input logic [PW-1:0]    arb_ptr
);

  for (genvar i = 0; i < N; i++) begin : g_one
    op_e op;
    assign op = op_e'(req_op[i*3 +: 3]);

    p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err[i] |-> (rsp_ready[i] && rsp_rdata[i*SW +: SW] == '0));

    p_tas_takes_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tas_win[i] |=> sem_all[$past(sem_idx[i*SIW +: SIW])]);

    p_tas_waits_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (act[i] && op == OP_SEM_TAS && !rsp_ready[i]) |-> (tgt_bit[i] || lost[i]));

    p_clrset_nowait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act[i] && (op == OP_SEM_CLR || op == OP_SEM_SET)) |-> rsp_ready[i]);

    for (genvar j = i + 1; j < N; j++) begin : g_pair
      p_tas_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(tas_win[i] && tas_win[j] &&
          sem_idx[i*SIW +: SIW] == sem_idx[j*SIW +: SIW]));
    end
  end

  p_ptr_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|lost) |=> (arb_ptr == PW'((int'($past(arb_ptr)) + 1) % N)));

  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|lost) |=> $stable(arb_ptr));

endmodule

bind shared_sync_cluster ssc_checker #(
  .N(NUM_CPU), .NC(NUM_CLUSTERS), .NS(NUM_SEMS), .SW(SCAL_W), .SIW(CLW + IDXW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_op    (req_op),
  .rsp_ready (rsp_ready),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .act       (act),
  .tas_win   (tas_win),
  .lost      (lost),
  .tgt_bit   (tgt_bit),
  .sem_idx   (sem_idx),
  .sem_all   (sem_all),
  .arb_ptr   (arb_ptr)
);

// File: tb/shared_sync_cluster_tb.sv
module shared_sync_cluster_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int SELW = 5;
  localparam int IDXW = 5;
  localparam int SW  = 64;

  localparam logic [2:0] RDA = 3'd0, WRA = 3'd1, RDS = 3'd2, WRS = 3'd3,
                         TAS = 3'd4, CLR = 3'd5, SET = 3'd6, ALL = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]      sel_we = '0;
  logic [N*SELW-1:0] sel_val = '0;
  logic [N-1:0]      req_valid = '0;
  logic [N*3-1:0]    req_op = '0;
  logic [N*IDXW-1:0] req_idx = '0;
  logic [N*SW-1:0]   req_wdata = '0;
  logic [N-1:0]      rsp_ready;
  logic [N-1:0]      rsp_err;
  logic [N*SW-1:0]   rsp_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  shared_sync_cluster u_dut (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_val(sel_val),
    .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
    .req_wdata(req_wdata), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic [1:0]  cpu;
    logic [2:0]  op;
    logic [4:0]  idx;
    logic [63:0] wd;
    logic        rdy;
    logic        err;
    logic [63:0] rd;
  } vec_t;

  // one request per cycle; cpu0,cpu1 -> cluster 2, cpu2 -> cluster 4, cpu3 unselected
  localparam vec_t VECS [17] = '{
    '{2'd0, WRA, 5'd2,  64'h0000_00FF_ABCD_EF12, 1'b1, 1'b0, 64'h0},                    // R3
    '{2'd1, RDA, 5'd2,  64'h0,                   1'b1, 1'b0, 64'h0000_0000_00CD_EF12},  // R3
    '{2'd2, RDA, 5'd2,  64'h0,                   1'b1, 1'b0, 64'h0},                    // R3 other cluster
    '{2'd2, WRS, 5'd7,  64'hDEAD_BEEF_0123_4567, 1'b1, 1'b0, 64'h0},                    // R4
    '{2'd2, RDS, 5'd7,  64'h0,                   1'b1, 1'b0, 64'hDEAD_BEEF_0123_4567},  // R4
    '{2'd0, RDS, 5'd7,  64'h0,                   1'b1, 1'b0, 64'h0},                    // R4 other cluster
    '{2'd3, RDA, 5'd2,  64'h0,                   1'b1, 1'b1, 64'h0},                    // R2
    '{2'd3, WRS, 5'd0,  64'h5,                   1'b1, 1'b1, 64'h0},                    // R2
    '{2'd0, TAS, 5'd31, 64'h0,                   1'b1, 1'b0, 64'h0},                    // R5
    '{2'd1, TAS, 5'd31, 64'h0,                   1'b0, 1'b0, 64'h0},                    // R5 waits
    '{2'd1, ALL, 5'd0,  64'h0,                   1'b1, 1'b0, 64'h0000_0000_8000_0000},  // R7
    '{2'd0, SET, 5'd0,  64'h0,                   1'b1, 1'b0, 64'h0},                    // R6
    '{2'd1, ALL, 5'd0,  64'h0,                   1'b1, 1'b0, 64'h0000_0000_8000_0001},  // R7
    '{2'd0, CLR, 5'd31, 64'h0,                   1'b1, 1'b0, 64'h0},                    // R6
    '{2'd1, TAS, 5'd31, 64'h0,                   1'b1, 1'b0, 64'h0},                    // R5 after clear
    '{2'd2, ALL, 5'd0,  64'h0,                   1'b1, 1'b0, 64'h0},                    // R7 other cluster
    '{2'd1, ALL, 5'd0,  64'h0,                   1'b1, 1'b0, 64'h0000_0000_8000_0001}   // R7
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int cpu, input logic [2:0] op, input logic [4:0] idx,
                     input logic [63:0] wd);
    req_valid[cpu] = 1'b1;
    req_op[cpu*3 +: 3] = op;
    req_idx[cpu*IDXW +: IDXW] = idx;
    req_wdata[cpu*SW +: SW] = wd;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    req_valid = '0;
    sel_we = '0;
  endtask

  task automatic settle();
    #4;
  endtask

  function automatic logic [63:0] rd(input int cpu);
    return rsp_rdata[cpu*SW +: SW];
  endfunction

  task automatic set_sel(input int cpu, input logic [4:0] v);
    sel_we[cpu] = 1'b1;
    sel_val[cpu*SELW +: SELW] = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R1: select registers reset to 0, so requests are refused
    put(0, RDA, 5'd0, 64'h0);
    settle();
    chk("R1 err after reset", {63'h0, rsp_err[0]}, 64'h1);
    chk("R1 ready after reset", {63'h0, rsp_ready[0]}, 64'h1);
    tick();

    set_sel(0, 5'd3); set_sel(1, 5'd3); set_sel(2, 5'd5); set_sel(3, 5'd0);
    tick();

    for (int v = 0; v < 17; v++) begin
      put(int'(VECS[v].cpu), VECS[v].op, VECS[v].idx, VECS[v].wd);
      settle();
      chk($sformatf("vector %0d ready", v), {63'h0, rsp_ready[VECS[v].cpu]}, {63'h0, VECS[v].rdy});
      chk($sformatf("vector %0d err", v), {63'h0, rsp_err[VECS[v].cpu]}, {63'h0, VECS[v].err});
      chk($sformatf("vector %0d rdata", v), rd(int'(VECS[v].cpu)), VECS[v].rd);
      tick();
    end

    // R8: pointer 0, both test-and-set bit 5 of cluster 2 -> cpu0 wins
    put(0, TAS, 5'd5, 64'h0); put(1, TAS, 5'd5, 64'h0);
    settle();
    chk("R8 tas winner cpu0", {63'h0, rsp_ready[0]}, 64'h1);
    chk("R8 tas loser cpu1", {63'h0, rsp_ready[1]}, 64'h0);
    tick();
    put(1, TAS, 5'd5, 64'h0);
    settle();
    chk("R5 held while set", {63'h0, rsp_ready[1]}, 64'h0);
    tick();
    put(0, CLR, 5'd5, 64'h0); put(1, TAS, 5'd5, 64'h0);
    settle();
    chk("R6 clear completes", {63'h0, rsp_ready[0]}, 64'h1);
    chk("R5 sees old bit", {63'h0, rsp_ready[1]}, 64'h0);
    tick();
    put(1, TAS, 5'd5, 64'h0);
    settle();
    chk("R5 acquires after clear", {63'h0, rsp_ready[1]}, 64'h1);
    tick();

    // R9/R10: pointer now 1, same-register writes -> cpu1 wins
    put(0, WRA, 5'd4, 64'h111); put(1, WRA, 5'd4, 64'h222);
    settle();
    chk("R9 ptr1 winner cpu1", {63'h0, rsp_ready[1]}, 64'h1);
    chk("R10 loser cpu0 waits", {63'h0, rsp_ready[0]}, 64'h0);
    tick();
    put(0, WRA, 5'd4, 64'h111);
    settle();
    chk("R10 retry completes", {63'h0, rsp_ready[0]}, 64'h1);
    tick();
    put(1, RDA, 5'd4, 64'h0);
    settle();
    chk("R10 serial order", rd(1), 64'h111);
    tick();

    // R9: pointer now 2 -> cpu0 outranks cpu1; cpu2 on its own cluster unaffected
    put(0, TAS, 5'd9, 64'h0); put(1, TAS, 5'd9, 64'h0); put(2, TAS, 5'd9, 64'h0);
    settle();
    chk("R9 ptr2 winner cpu0", {63'h0, rsp_ready[0]}, 64'h1);
    chk("R9 ptr2 loser cpu1", {63'h0, rsp_ready[1]}, 64'h0);
    chk("R8 other cluster free", {63'h0, rsp_ready[2]}, 64'h1);
    tick();

    // R10: pointer 3, different registers complete together
    put(0, WRS, 5'd1, 64'hAAAA_0000_0000_0001); put(1, WRS, 5'd2, 64'hBBBB_0000_0000_0002);
    settle();
    chk("R10 distinct cpu0", {63'h0, rsp_ready[0]}, 64'h1);
    chk("R10 distinct cpu1", {63'h0, rsp_ready[1]}, 64'h1);
    tick();
    put(0, RDS, 5'd2, 64'h0); put(1, RDS, 5'd1, 64'h0);
    settle();
    chk("R4 cross read cpu0", rd(0), 64'hBBBB_0000_0000_0002);
    chk("R4 cross read cpu1", rd(1), 64'hAAAA_0000_0000_0001);
    tick();

    // R9: pointer 3 -> cpu0 rank 1, cpu1 rank 2
    put(0, WRS, 5'd3, 64'hC); put(1, WRS, 5'd3, 64'hD);
    settle();
    chk("R9 ptr3 winner cpu0", {63'h0, rsp_ready[0]}, 64'h1);
    chk("R9 ptr3 loser cpu1", {63'h0, rsp_ready[1]}, 64'h0);
    tick();
    put(1, WRS, 5'd3, 64'hD);
    tick();
    put(0, RDS, 5'd3, 64'h0);
    settle();
    chk("R10 last writer value", rd(0), 64'hD);
    tick();

    // R6: set and clear on one bit in one cycle, set wins
    put(0, SET, 5'd12, 64'h0); put(1, CLR, 5'd12, 64'h0);
    settle();
    chk("R6 set ready", {63'h0, rsp_ready[0]}, 64'h1);
    chk("R6 clear ready", {63'h0, rsp_ready[1]}, 64'h1);
    tick();
    put(0, ALL, 5'd0, 64'h0);
    settle();
    chk("R6 R7 set dominates", rd(0), 64'h0000_0000_8000_1221);
    tick();

    // R11: read in the write cycle sees the old value
    put(0, WRA, 5'd6, 64'h777); put(1, RDA, 5'd6, 64'h0);
    settle();
    chk("R11 same cycle old value", rd(1), 64'h0);
    tick();
    put(1, RDA, 5'd6, 64'h0);
    settle();
    chk("R11 next cycle new value", rd(1), 64'h777);
    tick();

    put(2, ALL, 5'd0, 64'h0);
    settle();
    chk("R7 cluster 4 word", rd(2), 64'h200);
    tick();

    // R2: refused requests left no trace in any cluster
    set_sel(3, 5'd16);
    tick();
    put(3, RDS, 5'd0, 64'h0);
    settle();
    chk("R2 sel16 err clear", {63'h0, rsp_err[3]}, 64'h0);
    chk("R2 refused write absent", rd(3), 64'h0);
    tick();
    set_sel(3, 5'd17);
    tick();
    put(3, WRA, 5'd0, 64'h55);
    settle();
    chk("R2 sel17 refused", {62'h0, rsp_err[3], rsp_ready[3]}, 64'h3);
    tick();
    set_sel(3, 5'd1);
    tick();
    put(3, RDA, 5'd0, 64'h0);
    settle();
    chk("R2 cluster0 untouched", rd(3), 64'h0);
    chk("R1 cluster0 reset value err", {63'h0, rsp_err[3]}, 64'h0);
    tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule